// File: doc/BRIEF.md
# Overlapping Register Window File

This block is the general-purpose register file of a RISC core whose procedure calls switch register sets rather than saving them. Logical register numbers 0 to 31 are remapped through a current window index onto a circular pool of physical registers. Eight logical registers are global and are seen the same way from every window. The other 24 registers form three groups of eight: incoming arguments, private locals and outgoing arguments. A window's outgoing group is the same storage as the incoming group of the window one level deeper. A caller therefore hands arguments to a callee without copying anything.

A call strobe moves the current window up by one and a return strobe moves it down by one. One window is always held in reserve, and an internal marker tracks its position. That marker also records which window is next to be brought back from memory. When a call would run into the reserved window, the block raises an overflow trap. It then streams the oldest resident window out as words over a valid/ready handshake, and after the last word the call completes. When a return would land on the reserved window, the block raises an underflow trap. It then takes that window's words back in over a second handshake, and after the last word the return completes. The core issues reads on two ports and writes on one port, all by logical number, and waits while a trap is active.

Top module: `windowed_regfile`

## Requirements
- R1: After reset the current window is 0, both traps are low, spill_valid and fill_ready are low, and window 7 is the reserved (next-to-restore) window.
- R2: Logical register 0 always reads as zero, and writes to it are discarded.
- R3: Logical registers 1 to 7 are global: a value written in one window reads back unchanged in any other window.
- R4: Logical registers 24+k of window w and logical registers 8+k of window w+1 are the same storage (k = 0..7), so a value written through either name is read through the other.
- R5: Logical registers 16 to 23 are private to each window: a write in a deeper window does not change the caller's value.
- R6: An accepted call increments the current window modulo 8, and an accepted return decrements it. If both strobes are high in the same cycle, only the call takes effect.
- R7: A read of the register being written in the same cycle returns the new write data on both read ports.
- R8: A call that would make the current window equal to the reserved window raises ovf_trap and spill_valid. It then sends the 16 words of the oldest resident window in ascending order: incoming registers 8..15 first, then locals 16..23. After the 16th accepted word the trap drops, the reserved marker advances, and the current window increments.
- R9: A spill word is consumed only in a cycle with spill_ready high. While spill_ready is low, spill_valid stays high and spill_data holds its value.
- R10: A return that would make the current window equal to the reserved window raises unf_trap and fill_ready. It writes 16 words, one per cycle with fill_valid high, into that window's incoming registers and then its locals, in ascending order. After the 16th word the trap drops, the reserved marker steps back, and the current window decrements.
- R11: While either trap is high, call strobes, return strobes and register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call | input | 1 | Procedure call strobe |
| ret | input | 1 | Procedure return strobe |
| ra1 | input | 5 | Logical read address, port 1 |
| ra2 | input | 5 | Logical read address, port 2 |
| rd1 | output | W | Read data, port 1 |
| rd2 | output | W | Read data, port 2 |
| we | input | 1 | Write enable |
| wa | input | 5 | Logical write address |
| wd | input | W | Write data |
| cur_win | output | log2(NWIN) | Current window index |
| ovf_trap | output | 1 | Overflow trap, high during a spill |
| unf_trap | output | 1 | Underflow trap, high during a fill |
| spill_valid | output | 1 | Spill word available |
| spill_ready | input | 1 | Spill word accepted |
| spill_data | output | W | Spill word |
| fill_ready | output | 1 | Block accepts a fill word |
| fill_valid | input | 1 | Fill word present |
| fill_data | input | W | Fill word |

## Verification
A corrupted current-window index shows up at once on rd1 and rd2, because every windowed read goes through it in the same cycle. It also shows on cur_win right after the strobe. A wrong reserved-window marker stays hidden until the call or return that reaches it. At that point a trap fires one nesting level early or late, or the spill stream carries another window's words. The spill stream is checked word by word, and the filled window is read back after the return, so an error in the order of the streamed words is caught within 16 beats.

// File: rtl/windowed_regfile.sv
module windowed_regfile #(
  parameter int NWIN = 8,
  parameter int W    = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    call,
  input  logic                    ret,
  input  logic [4:0]              ra1,
  input  logic [4:0]              ra2,
  output logic [W-1:0]            rd1,
  output logic [W-1:0]            rd2,
  input  logic                    we,
  input  logic [4:0]              wa,
  input  logic [W-1:0]            wd,
  output logic [$clog2(NWIN)-1:0] cur_win,
  output logic                    ovf_trap,
  output logic                    unf_trap,
  output logic                    spill_valid,
  input  logic                    spill_ready,
  output logic [W-1:0]            spill_data,
  output logic                    fill_ready,
  input  logic                    fill_valid,
  input  logic [W-1:0]            fill_data
);
  localparam int WB = $clog2(NWIN);
  localparam int PW = NWIN * 16;
  localparam int IB = $clog2(PW + 8);

  typedef enum logic [1:0] {IDLE, SPILL, FILL} st_t;

  st_t           st;
  logic [WB-1:0] cwp, swp;
  logic [3:0]    cnt;
  logic [W-1:0]  mem [PW+8];

  function automatic logic [IB-1:0] map(input logic [WB-1:0] win, input logic [4:0] lr);
    logic [WB+3:0] off;
    if (lr < 5'd8) return IB'(PW) + IB'(lr);
    off = {win, 4'b0000} + (WB+4)'(lr - 5'd8);
    return IB'(off);
  endfunction

  logic [IB-1:0] widx, ridx1, ridx2, sidx, fidx;
  logic          wr_ok, last_beat;
  logic [WB-1:0] cwp_up, cwp_dn;

  assign widx   = map(cwp, wa);
  assign ridx1  = map(cwp, ra1);
  assign ridx2  = map(cwp, ra2);
  assign sidx   = IB'({WB'(swp + 1'b1), cnt});
  assign fidx   = IB'({swp, cnt});
  assign wr_ok  = (st == IDLE) && we && (wa != 5'd0);
  assign cwp_up = WB'(cwp + 1'b1);
  assign cwp_dn = WB'(cwp - 1'b1);

  assign rd1 = (ra1 == 5'd0) ? '0 : (wr_ok && widx == ridx1) ? wd : mem[ridx1];
  assign rd2 = (ra2 == 5'd0) ? '0 : (wr_ok && widx == ridx2) ? wd : mem[ridx2];

  assign cur_win     = cwp;
  assign ovf_trap    = (st == SPILL);
  assign unf_trap    = (st == FILL);
  assign spill_valid = (st == SPILL);
  assign fill_ready  = (st == FILL);
  assign spill_data  = mem[sidx];
  assign last_beat   = (cnt == 4'hF) &&
                       ((spill_valid && spill_ready) || (fill_ready && fill_valid));

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= IDLE;
      cwp <= '0;
      swp <= WB'(NWIN - 1);
      cnt <= '0;
    end else begin
      case (st)
        IDLE: begin
          cnt <= '0;
          if (call) begin
            if (cwp_up == swp) st <= SPILL;
            else cwp <= cwp_up;
          end else if (ret) begin
            if (cwp_dn == swp) st <= FILL;
            else cwp <= cwp_dn;
          end
        end
        SPILL: if (spill_ready) begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'hF) begin
            swp <= WB'(swp + 1'b1);
            cwp <= cwp_up;
            st  <= IDLE;
          end
        end
        FILL: if (fill_valid) begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'hF) begin
            swp <= WB'(swp - 1'b1);
            cwp <= cwp_dn;
            st  <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[widx] <= wd;
    else if (st == FILL && fill_valid) mem[fidx] <= fill_data;
  end

  assert_win_step_R6: assert property (@(posedge clk) disable iff (rst)
    (cwp != $past(cwp)) |-> (cwp == WB'($past(cwp) + 1'b1) || cwp == WB'($past(cwp) - 1'b1)));

  assert_no_collide_R8: assert property (@(posedge clk) disable iff (rst)
    cwp != swp);

  assert_spill_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (spill_valid && !spill_ready) |=> (spill_valid && $stable(spill_data)));

  assert_marker_move_R10: assert property (@(posedge clk) disable iff (rst)
    (swp != $past(swp)) |-> ($past(st) != IDLE));

  assert_trap_freeze_R11: assert property (@(posedge clk) disable iff (rst)
    ((ovf_trap || unf_trap) && !last_beat) |=> ($stable(cwp) && $stable(swp)));
endmodule

// File: tb/sim_windowed_regfile.sv
`timescale 1ns/1ps
module sim_windowed_regfile;
  logic        clk = 0, rst = 1;
  logic        call = 0, ret = 0, we = 0;
  logic [4:0]  ra1 = 0, ra2 = 0, wa = 0;
  logic [31:0] wd = 0, fill_data = 0;
  logic        spill_ready = 0, fill_valid = 0;
  logic [31:0] rd1, rd2, spill_data;
  logic [2:0]  cur_win;
  logic        ovf_trap, unf_trap, spill_valid, fill_ready;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  windowed_regfile u0 (.clk, .rst, .call, .ret, .ra1, .ra2, .rd1, .rd2, .we, .wa, .wd,
    .cur_win, .ovf_trap, .unf_trap, .spill_valid, .spill_ready, .spill_data,
    .fill_ready, .fill_valid, .fill_data);

  localparam logic [68:0] VEC [9] = '{
    {5'd1,  32'hAAAA_0001, 32'hAAAA_0001},
    {5'd0,  32'hFFFF_FFFF, 32'h0000_0000},
    {5'd7,  32'h7777_0007, 32'h7777_0007},
    {5'd8,  32'h0800_0008, 32'h0800_0008},
    {5'd15, 32'h0F00_000F, 32'h0F00_000F},
    {5'd16, 32'h1000_0010, 32'h1000_0010},
    {5'd23, 32'h1700_0017, 32'h1700_0017},
    {5'd24, 32'h1800_0018, 32'h1800_0018},
    {5'd31, 32'h1F00_001F, 32'h1F00_001F}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step; @(posedge clk); #1; endtask
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    we = 1; wa = a; wd = d; step; we = 0;
  endtask
  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    ra1 = a; #0.2; d = rd1;
  endtask
  task automatic do_call; call = 1; step; call = 0; endtask
  task automatic do_ret;  ret = 1;  step; ret = 0;  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) step;
    rst = 0;
    step;
    // R1 reset state
    chk("R1 cur_win", 32'(cur_win), 0);
    chk("R1 traps", {30'd0, ovf_trap, unf_trap}, 0);
    chk("R1 handshakes", {30'd0, spill_valid, fill_ready}, 0);

    // vector table walk (R2 r0, R3 globals, windowed names)
    foreach (VEC[i]) begin
      wr(VEC[i][68:64], VEC[i][63:32]);
      ra1 = VEC[i][68:64]; ra2 = VEC[i][68:64]; #0.2;
      chk("R2/R3 table rd1", rd1, VEC[i][31:0]);
      chk("R2/R3 table rd2", rd2, VEC[i][31:0]);
    end

    // R7 same-cycle bypass, and R2 bypass of r0
    we = 1; wa = 5'd5; wd = 32'hB1B1_0005; ra1 = 5'd5; ra2 = 5'd5; #0.2;
    chk("R7 bypass rd1", rd1, 32'hB1B1_0005);
    chk("R7 bypass rd2", rd2, 32'hB1B1_0005);
    step; we = 0;
    we = 1; wa = 5'd0; wd = 32'h1234_5678; ra1 = 5'd0; #0.2;
    chk("R2 r0 bypass", rd1, 0);
    step; we = 0;

    // R4 overlap both directions, R5 locals private, R3 global visibility
    wr(5'd16, 32'hA0A0_0016);
    wr(5'd24, 32'hC0C0_0024);
    do_call;
    chk("R6 call increments", 32'(cur_win), 1);
    rd(5'd8, v);  chk("R4 out->in overlap", v, 32'hC0C0_0024);
    rd(5'd1, v);  chk("R3 global in window 1", v, 32'hAAAA_0001);
    wr(5'd16, 32'hB0B0_0016);
    wr(5'd9, 32'hD0D0_0009);
    do_ret;
    chk("R6 return decrements", 32'(cur_win), 0);
    rd(5'd16, v); chk("R5 caller local kept", v, 32'hA0A0_0016);
    rd(5'd25, v); chk("R4 in->out overlap", v, 32'hD0D0_0009);

    // R6 both strobes: call wins
    call = 1; ret = 1; step; call = 0; ret = 0;
    chk("R6 call priority", 32'(cur_win), 1);
    do_ret;

    // set up window 0 incoming+locals for the spill
    for (int i = 0; i < 16; i++) wr(5'(8 + i), 32'h100 + i);
    for (int i = 0; i < 6; i++) do_call;
    chk("R8 six calls without trap", {29'd0, cur_win}, 6);
    chk("R8 no trap yet", {31'd0, ovf_trap}, 0);

    // R8 overflow on the seventh call
    do_call;
    chk("R8 ovf_trap raised", {31'd0, ovf_trap}, 1);
    chk("R8 spill_valid raised", {31'd0, spill_valid}, 1);
    chk("R8 call held", 32'(cur_win), 6);
    // R11: strobes and writes ignored while trapped; R9 hold with ready low
    ret = 1; we = 1; wa = 5'd1; wd = 32'hDEAD_BEEF; step; ret = 0; we = 0;
    chk("R9 word held", spill_data, 32'h100);
    chk("R11 window frozen", 32'(cur_win), 6);
    for (int i = 0; i < 16; i++) begin
      spill_ready = 1; #0.2;
      chk("R8 spill word order", spill_data, 32'h100 + i);
      step;
    end
    spill_ready = 0;
    chk("R8 call completes", 32'(cur_win), 7);
    chk("R8 trap dropped", {31'd0, ovf_trap}, 0);
    rd(5'd1, v); chk("R11 write ignored while trapped", v, 32'hAAAA_0001);

    // R10 underflow: return from 7 down to 1 freely, then onto spilled window 0
    for (int i = 0; i < 6; i++) do_ret;
    chk("R10 returns without trap", 32'(cur_win), 1);
    do_ret;
    chk("R10 unf_trap raised", {31'd0, unf_trap}, 1);
    chk("R10 fill_ready raised", {31'd0, fill_ready}, 1);
    step;
    chk("R10 return held during gap", 32'(cur_win), 1);
    for (int i = 0; i < 16; i++) begin
      fill_valid = 1; fill_data = 32'h200 + i; step;
    end
    fill_valid = 0;
    chk("R10 return completes", 32'(cur_win), 0);
    chk("R10 trap dropped", {31'd0, unf_trap}, 0);
    for (int i = 0; i < 16; i++) begin
      rd(5'(8 + i), v); chk("R10 filled register", v, 32'h200 + i);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule